// File: doc/BRIEF.md
# Majority-Vote Serial Receiver

This block receives asynchronous serial frames of ten bits: a low start bit, eight data bits sent least significant bit first, and a stop bit. The line is resynchronised by two flops and then examined only on an enable pulse, `tick16`. The pulse comes from outside the block and runs at sixteen times the baud rate. A falling edge seen on a tick starts a frame and restarts the sixteen-state phase counter. Each bit is settled by a two-of-three vote over three neighbouring phases near the middle of the bit.

The frame end is not found by counting bits. A nine-bit shift register is filled with ones when the start is detected. Accepted bits enter at the right, and the frame is over when the zero of the start bit reaches the leftmost flop. The next accepted bit is the stop bit, and it is taken with one final shift.

The frame is committed only under two conditions. The receive-complete flag must be clear, so that software has collected the previous byte. When the multiprocessor mode is enabled, the stop bit must also be one. A frame that fails either condition is discarded. In every case the receiver goes back to watching for a new falling edge.

Top module: `mvote_uart_rx`

## Requirements
- R1: While `rstN` is low and just after it is released, `rxData` is 0x00 and `stopBit`, `rxDone` and `overrun` are 0.
- R2: A frame begins only when a `tick16` pulse sees the synchronised line low after the previous tick saw it high. A line held high changes no output.
- R3: With the phase counter reset to 0 at the start tick, each bit is sampled at counter states 7, 8 and 9. The bit value is the majority of the three samples, so a single corrupted sample is outvoted and two corrupted samples flip the bit.
- R4: If the vote for the start bit gives 1, the frame is abandoned without touching any output, and the next falling edge starts a fresh frame.
- R5: The frame ends when the start bit has been shifted into the leftmost of the nine register positions. The stop bit is the next voted bit, so `rxDone` is still 0 once start and data bits have been received, before the stop bit.
- R6: On a commit, `rxData` takes the eight data bits with the first received bit in bit 0, `stopBit` takes the voted stop bit, and `rxDone` becomes 1.
- R7: A frame that ends while `rxDone` is 1 is dropped. `rxData` and `stopBit` keep their old values, and the sticky `overrun` becomes 1.
- R8: With `mpEnable` at 1, a frame whose stop bit is 0 is dropped without setting `rxDone` or `overrun`, and a frame whose stop bit is 1 is committed. With `mpEnable` at 0, the stop bit value does not gate the commit.
- R9: A one-cycle `flagClr` pulse clears `rxDone` and `overrun`. If a commit and `flagClr` fall in the same cycle, the commit wins, so `rxDone` is 1 for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at sixteen times the baud rate |
| lineIn | input | 1 | Asynchronous serial input, idle high |
| mpEnable | input | 1 | Multiprocessor mode: when 1, only frames with stop bit 1 are committed |
| flagClr | input | 1 | Software pulse that clears `rxDone` and `overrun` |
| rxData | output | 8 | Last committed data byte |
| stopBit | output | 1 | Stop bit of the last committed frame |
| rxDone | output | 1 | Receive-complete flag |
| overrun | output | 1 | Sticky flag: a frame was lost because `rxDone` was still set |

## Verification
The bench corrupts the line for exactly one sampling phase, and then for two. A receiver that trusted a single sample would lose the byte in the first case, and one that ignored the vote would keep the byte in the second. A short low glitch followed by a real frame checks that a false start is rejected and that edge hunting resumes; a receiver that stayed stuck would miss the real frame. The bench reads `rxDone` just before the stop bit, which catches a frame end counted one bit early. It also covers frames that arrive while the flag is still set and the multiprocessor stop-bit filter: a design that got these wrong would overwrite unread data or pass filtered frames. Holding `flagClr` high across a commit checks that a set beats a simultaneous clear.

// File: rtl/mvrx_pkg.sv
package mvrx_pkg;

  typedef enum logic {
    ST_HUNT,
    ST_FRAME
  } rxState_t;

  typedef struct packed {
    logic loadOnes;
    logic sampleA;
    logic sampleB;
    logic shiftIn;
    logic commit;
    logic overrunSet;
  } rxStrobe_t;

endpackage

// File: rtl/mvrx_ctrl.sv
module mvrx_ctrl
  import mvrx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      fallEdge,
  input  logic      voteBit,
  input  logic      firstPend,
  input  logic      markerHit,
  input  logic      doneFlag,
  input  logic      mpEnable,
  output rxStrobe_t stb
);

  localparam int CNT_W = $clog2(OSR);
  localparam logic [CNT_W-1:0] PT_A = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] PT_B = CNT_W'(OSR / 2);
  localparam logic [CNT_W-1:0] PT_C = CNT_W'(OSR / 2 + 1);

  rxState_t         state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;

  always_comb begin
    stb       = '0;
    stateNext = state;
    cntNext   = cnt;
    unique case (state)
      ST_HUNT: begin
        if (tick16 && fallEdge) begin
          stb.loadOnes = 1'b1;
          cntNext      = '0;
          stateNext    = ST_FRAME;
        end
      end
      ST_FRAME: begin
        if (tick16) begin
          cntNext = cnt + CNT_W'(1);
          if (cnt == PT_A) stb.sampleA = 1'b1;
          if (cnt == PT_B) stb.sampleB = 1'b1;
          if (cnt == PT_C) begin
            if (firstPend && voteBit) begin
              stateNext = ST_HUNT;
            end else begin
              stb.shiftIn = 1'b1;
              if (markerHit) begin
                stateNext = ST_HUNT;
                if (!doneFlag && (!mpEnable || voteBit)) stb.commit = 1'b1;
                else if (doneFlag) stb.overrunSet = 1'b1;
              end
            end
          end
        end
      end
      default: stateNext = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_HUNT;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  // R3: the phase counter only moves on a tick
  p_hold_cnt_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FRAME && !tick16) |=> $stable(cnt));

  // R6: strobes that belong to different phases never coincide
  p_excl_stb_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadOnes, stb.sampleA, stb.sampleB, stb.commit, stb.overrunSet}));

  // R5: a finished frame always returns to edge hunting
  p_end_hunt_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.commit || stb.overrunSet) |=> (state == ST_HUNT));

endmodule

// File: rtl/mvrx_dp.sv
module mvrx_dp
  import mvrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              lineIn,
  input  logic              flagClr,
  input  rxStrobe_t         stb,
  output logic              fallEdge,
  output logic              voteBit,
  output logic              firstPend,
  output logic              markerHit,
  output logic [DATA_W-1:0] rxData,
  output logic              stopBit,
  output logic              rxDone,
  output logic              overrun
);

  localparam int SR_W = DATA_W + 1;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineS, prevLine;
  logic                   sampA, sampB;
  logic [SR_W-1:0]        shReg;
  logic [DATA_W-1:0]      frameByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end
  assign lineS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       prevLine <= 1'b1;
    else if (tick16) prevLine <= lineS;
  end
  assign fallEdge = prevLine & ~lineS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampA <= 1'b1;
      sampB <= 1'b1;
    end else begin
      if (stb.sampleA) sampA <= lineS;
      if (stb.sampleB) sampB <= lineS;
    end
  end
  assign voteBit = (sampA & sampB) | (sampA & lineS) | (sampB & lineS);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shReg <= '1;
    else if (stb.loadOnes) shReg <= '1;
    else if (stb.shiftIn)  shReg <= {shReg[SR_W-2:0], voteBit};
  end
  assign firstPend = &shReg;
  assign markerHit = ~shReg[SR_W-1];

  for (genvar g = 0; g < DATA_W; g++) begin : g_unscramble
    assign frameByte[g] = shReg[DATA_W-1-g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      stopBit <= 1'b0;
      rxDone  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (stb.commit) begin
        rxData  <= frameByte;
        stopBit <= voteBit;
      end
      if (stb.commit)   rxDone <= 1'b1;
      else if (flagClr) rxDone <= 1'b0;
      if (stb.overrunSet) overrun <= 1'b1;
      else if (flagClr)   overrun <= 1'b0;
    end
  end

  // R7: held data survives while the flag is up
  p_keep_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> $stable(rxData));

  // R9: a clear without a concurrent commit drops the flag
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !stb.commit) |=> !rxDone);

  // R2: a start reloads the marker register with ones
  p_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOnes |=> firstPend);

endmodule

// File: rtl/mvote_uart_rx.sv
module mvote_uart_rx
  import mvrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              lineIn,
  input  logic              mpEnable,
  input  logic              flagClr,
  output logic [DATA_W-1:0] rxData,
  output logic              stopBit,
  output logic              rxDone,
  output logic              overrun
);

  rxStrobe_t stb;
  logic      fallEdge, voteBit, firstPend, markerHit;

  mvrx_ctrl #(.OSR(OSR)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .fallEdge (fallEdge),
    .voteBit  (voteBit),
    .firstPend(firstPend),
    .markerHit(markerHit),
    .doneFlag (rxDone),
    .mpEnable (mpEnable),
    .stb      (stb)
  );

  mvrx_dp #(.DATA_W(DATA_W), .SYNC_STAGES(2)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .lineIn   (lineIn),
    .flagClr  (flagClr),
    .stb      (stb),
    .fallEdge (fallEdge),
    .voteBit  (voteBit),
    .firstPend(firstPend),
    .markerHit(markerHit),
    .rxData   (rxData),
    .stopBit  (stopBit),
    .rxDone   (rxDone),
    .overrun  (overrun)
  );

  // R8: in multiprocessor mode every newly committed frame has stop bit 1
  p_mp_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxDone) && $past(mpEnable)) |-> stopBit);

endmodule

// File: tb/test_mvote_uart_rx.sv
`timescale 1ns/1ps
module test_mvote_uart_rx;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       lineIn = 1'b1;
  logic       mpEnable = 1'b0;
  logic       flagClr = 1'b0;
  logic [7:0] rxData;
  logic       stopBit, rxDone, overrun;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;
  bit sawDone = 0;

  always #2 clk = ~clk;

  mvote_uart_rx i_mvote_uart_rx (
    .clk(clk), .rstN(rstN), .tick16(tick16), .lineIn(lineIn),
    .mpEnable(mpEnable), .flagClr(flagClr), .rxData(rxData),
    .stopBit(stopBit), .rxDone(rxDone), .overrun(overrun)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rxDone) sawDone = 1;
  endtask

  // one tick slot of four clocks; the line value is seen by the next slot's tick
  task automatic slot(input logic v);
    step();
    tick16 = 1'b1;
    lineIn = v;
    step();
    tick16 = 1'b0;
    step();
    step();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) slot(1'b1);
  endtask

  task automatic clearFlag();
    step();
    flagClr = 1'b1;
    step();
    flagClr = 1'b0;
    step();
  endtask

  // glitchBit: frame bit index whose slots in mask are inverted (-1 for none)
  task automatic sendFrame(input logic [7:0] d, input logic stopV, input int glitchBit,
                           input logic [15:0] mask, input bit midCheck);
    logic [9:0] bits;
    bits = {stopV, d, 1'b0};
    for (int b = 0; b < 10; b++) begin
      if (midCheck && b == 9) check("R5 done before stop bit", rxDone, 1'b0);
      for (int s = 0; s < 16; s++)
        slot(bits[b] ^ ((b == glitchBit) && mask[s]));
    end
    idle(4);
  endtask

  task automatic t_reset();
    check("R1 rxData", rxData, 8'h00);
    check("R1 stopBit", stopBit, 1'b0);
    check("R1 rxDone", rxDone, 1'b0);
    check("R1 overrun", overrun, 1'b0);
  endtask

  task automatic t_idle();
    idle(60);
    check("R2 idle rxDone", rxDone, 1'b0);
    check("R2 idle rxData", rxData, 8'h00);
  endtask

  task automatic t_basic();
    sendFrame(8'hA5, 1'b1, -1, 16'h0, 1'b1);
    check("R6 data", rxData, 8'hA5);
    check("R6 stop", stopBit, 1'b1);
    check("R6 done", rxDone, 1'b1);
    check("R6 no overrun", overrun, 1'b0);
    clearFlag();
    check("R9 clear", rxDone, 1'b0);
  endtask

  task automatic t_vote();
    // slot 9 feeds only the sample at state 8
    for (int b = 0; b < 10; b++) begin
      sendFrame(8'h3C, 1'b1, b, 16'h0200, 1'b0);
      check("R3 single bad sample outvoted", rxData, 8'h3C);
      check("R3 done", rxDone, 1'b1);
      clearFlag();
    end
    // slots 8 and 9 feed samples at states 7 and 8: data bit 0 flips
    sendFrame(8'h0F, 1'b1, 1, 16'h0300, 1'b0);
    check("R3 two bad samples flip bit", rxData, 8'h0E);
    clearFlag();
  endtask

  task automatic t_false_start();
    for (int i = 0; i < 3; i++) slot(1'b0);
    idle(30);
    check("R4 false start no done", rxDone, 1'b0);
    check("R4 false start data kept", rxData, 8'h0E);
    sendFrame(8'h5A, 1'b1, -1, 16'h0, 1'b0);
    check("R4 frame after false start", rxData, 8'h5A);
    clearFlag();
  endtask

  task automatic t_mp();
    mpEnable = 1'b1;
    sendFrame(8'h11, 1'b0, -1, 16'h0, 1'b0);
    check("R8 stop0 dropped done", rxDone, 1'b0);
    check("R8 stop0 dropped data", rxData, 8'h5A);
    check("R8 stop0 no overrun", overrun, 1'b0);
    sendFrame(8'h22, 1'b1, -1, 16'h0, 1'b0);
    check("R8 stop1 data", rxData, 8'h22);
    check("R8 stop1 done", rxDone, 1'b1);
    clearFlag();
    mpEnable = 1'b0;
    sendFrame(8'h77, 1'b0, -1, 16'h0, 1'b0);
    check("R8 mp off stop0 data", rxData, 8'h77);
    check("R6 stop0 captured", stopBit, 1'b0);
  endtask

  task automatic t_overrun();
    sendFrame(8'h99, 1'b1, -1, 16'h0, 1'b0);
    check("R7 data kept", rxData, 8'h77);
    check("R7 stop kept", stopBit, 1'b0);
    check("R7 overrun", overrun, 1'b1);
    check("R7 done still", rxDone, 1'b1);
    clearFlag();
    check("R9 clear done", rxDone, 1'b0);
    check("R9 clear overrun", overrun, 1'b0);
  endtask

  task automatic t_set_wins();
    step();
    flagClr = 1'b1;
    sawDone = 0;
    sendFrame(8'hC3, 1'b1, -1, 16'h0, 1'b0);
    check("R9 set beats clear", sawDone, 1'b1);
    check("R9 cleared after", rxDone, 1'b0);
    check("R9 data written", rxData, 8'hC3);
    flagClr = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    rstN = 1'b1;
    step();
    t_reset();
    t_idle();
    t_basic();
    t_vote();
    t_false_start();
    t_mp();
    t_overrun();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule